// File: doc/BRIEF.md
# Aging Priority Read Arbiter

This block chooses, once per clock, one of several read requesters to be served. Each requester owns a rank counter. When the requester is idle, or when it has just been served, the counter is loaded from a priority value that software programs. While the requester waits, the counter counts down, so a request that has waited a long time moves ahead of newer ones. The smallest counter wins.

Two per-port qualifiers can override the counter order. An urgent signal outranks everything else. A page-hit signal outranks the counter among requests of the same urgency. Each port has its own configuration bits that turn off aging, urgent handling or page-hit handling for that port. A further bit marks every grant to that port as a high-priority read.

The grant and the high-priority flag are registered, so they appear one clock after the request pattern that produced them.

Top module: `aging_rd_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `grant_o` and `grant_hpr_o` are 0. All rank counters reset to all ones, which is 0x3FF for a 10-bit priority and is the weakest rank.
- R2: `grant_o` is registered. It reflects the inputs sampled at the previous rising edge. It has at most one bit set, it never sets a bit whose `req_i` bit was 0, and it is nonzero exactly when `req_i` was nonzero. Bit p of `grant_o` means port p was granted.
- R3: Among candidates of equal urgency and page class, the port with the smaller rank counter is granted. Remaining ties go to the lowest port index.
- R4: A port's counter is loaded with its programmed priority (field p of `cfg_pri_i`, bits p*PRI_W upward) on every edge where the port is not requesting, and on every edge where it is requesting and is granted.
- R5: A port that is requesting but not granted, with aging enabled (`cfg_no_age_i[p]`=0), decrements its counter by one per cycle and saturates at zero. With `cfg_no_age_i[p]`=1 the counter holds its value.
- R6: A request with `urgent_i[p]`=1 and `cfg_no_urg_i[p]`=0 beats every request without an effective urgent, whatever the counters hold. With `cfg_no_urg_i[p]`=1 the port's urgent input has no effect.
- R7: Among requests of the same urgency class, a request with `page_hit_i[p]`=1 and `cfg_no_page_i[p]`=0 beats one without an effective page hit, whatever the counters hold. With `cfg_no_page_i[p]`=1 the page hit has no effect.
- R8: `grant_hpr_o` equals `cfg_hpr_i` of the port granted in the same cycle. It is 0 when no grant is issued.
- R9: With aging enabled on all ports, all priorities at least 1, and no effective urgent or page hit, a continuously requesting port waits at most 2^PRI_W + NUM_PORTS cycles for a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pri_i | input | NUM_PORTS*PRI_W | Programmed priority per port, lower is stronger |
| cfg_no_age_i | input | NUM_PORTS | Per-port disable of aging |
| cfg_no_urg_i | input | NUM_PORTS | Per-port disable of urgent |
| cfg_no_page_i | input | NUM_PORTS | Per-port disable of page-hit preference |
| cfg_hpr_i | input | NUM_PORTS | Per-port mark grants as high priority |
| req_i | input | NUM_PORTS | Request vector |
| urgent_i | input | NUM_PORTS | Per-port urgent input |
| page_hit_i | input | NUM_PORTS | Per-port page-hit input |
| grant_o | output | NUM_PORTS | One-hot grant, registered |
| grant_hpr_o | output | 1 | Granted read is high priority, registered |

## Verification
The bench builds the block with its defaults: four ports and 10-bit priorities. With these values the counters start at 0x3FF, and a directed case checks that a 0x0FF port beats a 0x3FF port. The starvation bound of R9 is 1028 cycles. To keep that phase short, the bench uses small priorities in the range 1 to 15, so saturation at zero and the tie-to-lowest-index rule are reached many times over. Random phases mix urgent, page-hit and all four disable bits, and a bench model of the counters predicts each grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // rank class bits placed above the counter: urgent, then page hit
  localparam int CLASS_W = 2;

  function automatic logic [CLASS_W-1:0] class_bits(input logic urg, input logic page);
    // lower value ranks stronger, so invert the qualifiers
    return {~urg, ~page};
  endfunction
endpackage

// File: rtl/aging_counter.sv
module aging_counter #(
  parameter int PRI_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             won,
  input  logic             no_age,
  input  logic [PRI_W-1:0] pri,
  output logic [PRI_W-1:0] cnt
);
  localparam logic [PRI_W-1:0] WEAKEST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= WEAKEST;
    end else if (!req || won) begin
      cnt <= pri;
    end else if (!no_age && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4: reload on grant or idle
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (!req || won) |=> (cnt == $past(pri)));
  // R5: decrement while waiting
  a_r5_age_down: assert property (@(posedge clk) disable iff (rst)
    (req && !won && !no_age && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R5: hold when aging off or saturated
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (req && !won && (no_age || cnt == '0)) |=> $stable(cnt));
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NUM_PORTS = 4,
  parameter int PRI_W     = 10,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0]       req,
  input  logic [NUM_PORTS-1:0]       urg_eff,
  input  logic [NUM_PORTS-1:0]       page_eff,
  input  logic [NUM_PORTS*PRI_W-1:0] cnt_flat,
  output logic                       win_valid,
  output logic [IDX_W-1:0]           win_idx,
  output logic [NUM_PORTS-1:0]       win_onehot
);
  import arb_pkg::*;
  localparam int KEY_W = CLASS_W + PRI_W;

  logic [KEY_W-1:0] key [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_key
    assign key[p] = {class_bits(urg_eff[p], page_eff[p]), cnt_flat[p*PRI_W +: PRI_W]};
  end

  always_comb begin
    logic [KEY_W-1:0] best;
    best       = '1;
    win_valid  = 1'b0;
    win_idx    = '0;
    // strict compare keeps the lowest index on a tie
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (req[p] && (!win_valid || key[p] < best)) begin
        best      = key[p];
        win_valid = 1'b1;
        win_idx   = IDX_W'(p);
      end
    end
    win_onehot = '0;
    if (win_valid) win_onehot[win_idx] = 1'b1;
  end
endmodule

// File: rtl/aging_rd_arbiter.sv
module aging_rd_arbiter #(
  parameter int NUM_PORTS = 4,
  parameter int PRI_W     = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS*PRI_W-1:0] cfg_pri_i,
  input  logic [NUM_PORTS-1:0]       cfg_no_age_i,
  input  logic [NUM_PORTS-1:0]       cfg_no_urg_i,
  input  logic [NUM_PORTS-1:0]       cfg_no_page_i,
  input  logic [NUM_PORTS-1:0]       cfg_hpr_i,
  input  logic [NUM_PORTS-1:0]       req_i,
  input  logic [NUM_PORTS-1:0]       urgent_i,
  input  logic [NUM_PORTS-1:0]       page_hit_i,
  output logic [NUM_PORTS-1:0]       grant_o,
  output logic                       grant_hpr_o
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_PORTS*PRI_W-1:0] cnt_flat;
  logic [NUM_PORTS-1:0]       urg_eff, page_eff, win_onehot;
  logic                       win_valid;
  logic [IDX_W-1:0]           win_idx;

  assign urg_eff  = urgent_i   & ~cfg_no_urg_i;
  assign page_eff = page_hit_i & ~cfg_no_page_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    aging_counter #(.PRI_W(PRI_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .req    (req_i[p]),
      .won    (win_onehot[p]),
      .no_age (cfg_no_age_i[p]),
      .pri    (cfg_pri_i[p*PRI_W +: PRI_W]),
      .cnt    (cnt_flat[p*PRI_W +: PRI_W])
    );
  end

  arb_pick #(.NUM_PORTS(NUM_PORTS), .PRI_W(PRI_W)) u_pick (
    .req        (req_i),
    .urg_eff    (urg_eff),
    .page_eff   (page_eff),
    .cnt_flat   (cnt_flat),
    .win_valid  (win_valid),
    .win_idx    (win_idx),
    .win_onehot (win_onehot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o     <= '0;
      grant_hpr_o <= 1'b0;
    end else begin
      grant_o     <= win_onehot;
      grant_hpr_o <= win_valid & cfg_hpr_i[win_idx];
    end
  end

  // R2: at most one grant
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_o));
  // R2: grant only to a port that requested
  a_r2_only_req: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant_o & ~$past(req_i)) == '0));
  // R2: any request yields a grant
  a_r2_served: assert property (@(posedge clk) disable iff (rst)
    (req_i != '0) |=> (grant_o != '0));
  // R8: no flag without a grant
  a_r8_hpr_needs_grant: assert property (@(posedge clk) disable iff (rst)
    grant_hpr_o |-> (grant_o != '0));
  // R6: an effective urgent request is never passed over for a non-urgent one
  a_r6_urgent_first: assert property (@(posedge clk) disable iff (rst)
    ((req_i & urg_eff) != '0) |=> ((grant_o & $past(urg_eff)) != '0));
endmodule

// File: tb/aging_rd_arbiter_bench.sv
module aging_rd_arbiter_bench;
  localparam int N = 4;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*W-1:0] cfg_pri = '1;
  logic [N-1:0] no_age = '0, no_urg = '0, no_page = '0, hpr = '0;
  logic [N-1:0] req = '0, urg = '0, page = '0;
  logic [N-1:0] grant;
  logic         grant_hpr;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mcnt [N];
  int wait_cnt [N];
  int max_wait = 0;
  bit track_wait = 0;

  always #2 clk = ~clk;

  aging_rd_arbiter #(.NUM_PORTS(N), .PRI_W(W)) u_aging_rd_arbiter (
    .clk(clk), .rst(rst), .cfg_pri_i(cfg_pri), .cfg_no_age_i(no_age),
    .cfg_no_urg_i(no_urg), .cfg_no_page_i(no_page), .cfg_hpr_i(hpr),
    .req_i(req), .urgent_i(urg), .page_hit_i(page),
    .grant_o(grant), .grant_hpr_o(grant_hpr)
  );

  function automatic int pick();
    int best = -1;
    logic [W+1:0] bk = '1;
    for (int p = 0; p < N; p++) begin
      logic [W+1:0] k;
      k = {~(urg[p] & ~no_urg[p]), ~(page[p] & ~no_page[p]), mcnt[p]};
      if (req[p] && (best < 0 || k < bk)) begin best = p; bk = k; end
    end
    return best;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_pri(input int p, input logic [W-1:0] v);
    cfg_pri[p*W +: W] = v;
  endtask

  // one clock: predict, advance model, compare after the edge
  task automatic cycle(input string tag);
    int w;
    logic [N-1:0] eg;
    logic eh;
    w = pick();
    eg = '0;
    eh = 1'b0;
    if (w >= 0) begin eg[w] = 1'b1; eh = hpr[w]; end
    for (int p = 0; p < N; p++) begin
      if (!req[p] || w == p) mcnt[p] = cfg_pri[p*W +: W];
      else if (!no_age[p] && mcnt[p] != 0) mcnt[p] = mcnt[p] - 1'b1;
      if (track_wait) begin
        if (req[p] && w != p) wait_cnt[p]++; else wait_cnt[p] = 0;
        if (wait_cnt[p] > max_wait) max_wait = wait_cnt[p];
      end
    end
    @(posedge clk); #1;
    check(tag, grant, eg);
    check({tag, " R8 flag"}, {{(N-1){1'b0}}, grant_hpr}, {{(N-1){1'b0}}, eh});
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin mcnt[p] = '1; wait_cnt[p] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset grant", grant, '0);
    check("R1 reset flag", {{(N-1){1'b0}}, grant_hpr}, '0);
    rst = 1'b0;
    // R1: counters start at weakest, port 0 wins the tie
    req = 4'b1111;
    cycle("R1 R3 first grant tie");
    req = '0;
    cycle("R2 no request no grant");
    // R3 directed: 0x3FF vs 0x0FF
    set_pri(0, 10'h3FF); set_pri(1, 10'h0FF); set_pri(2, 10'h3FF); set_pri(3, 10'h3FF);
    cycle("R4 idle load");
    req = 4'b0011;
    @(negedge clk);
    begin
      logic [N-1:0] g1;
      @(posedge clk); #1;
      g1 = grant;
      check("R3 lower value wins", g1, 4'b0010);
      mcnt[1] = 10'h0FF; mcnt[0] = 10'h3FE;
    end
    // R5 aging: port0 pri 4, port1 pri 2; aging lets port0 in
    req = '0; set_pri(0, 10'd4); set_pri(1, 10'd2);
    cycle("R4 reload idle");
    req = 4'b0011;
    repeat (8) cycle("R5 aging rotate");
    no_age = 4'b0001;
    repeat (6) cycle("R5 aging disabled hold");
    no_age = '0;
    // R6 urgent beats counter; disable ignores
    req = '0; cycle("R4 reload");
    set_pri(2, 10'h3FF); req = 4'b0110; urg = 4'b0100;
    cycle("R6 urgent wins");
    no_urg = 4'b0100;
    cycle("R6 urgent disabled");
    no_urg = '0; urg = '0;
    // R7 page hit beats counter; disable ignores
    req = '0; cycle("R4 reload");
    req = 4'b0110; page = 4'b0100;
    cycle("R7 page hit wins");
    no_page = 4'b0100;
    cycle("R7 page disabled");
    no_page = '0; page = '0;
    // R8 flag
    hpr = 4'b0010; req = 4'b0010;
    cycle("R8 hpr set");
    hpr = '0;
    // R9 starvation: small priorities, all requesting
    for (int p = 0; p < N; p++) set_pri(p, W'(1 + ($urandom % 15)));
    req = '0; cycle("R4 reload");
    req = '1; track_wait = 1;
    repeat (1500) cycle("R9 R5 fairness");
    track_wait = 0;
    check("R9 max wait", (max_wait <= (1 << W) + N) ? '1 : '0, '1);
    // random mix
    repeat (4000) begin
      @(negedge clk);
      req = N'($urandom); urg = N'($urandom) & N'($urandom);
      page = N'($urandom);
      no_age = N'($urandom) & N'($urandom); no_urg = N'($urandom) & N'($urandom);
      no_page = N'($urandom) & N'($urandom); hpr = N'($urandom);
      if (($urandom % 50) == 0) for (int p = 0; p < N; p++) set_pri(p, W'($urandom % 24));
      cycle("R2 R3 R6 R7 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule